// File: doc/BRIEF.md
# Cache Line Refill Read Responder

This block is the slave end of a cache-line refill. A requester asks for one line by giving a line number, a target word index and an ordering mode. The block then reads all eight words of that line from a small synchronous word store and returns them as a burst of eight consecutive beats. Each beat carries a word-position tag, and the requester uses that tag to put each word into the correct slot of its line. The order of the tags must therefore be exactly the order of the data.

There are two orderings. In the first, the line comes back from word 0 upward. In the second, the requested word comes first and the index then wraps around the line. Inside the block, a sequencer issues one store read per cycle. The store answers one cycle later with an internal acknowledge and the word index. A registered bus stage then drives the external acknowledge, data, tag and burst-complete pulse one cycle after that. The word index travels through the same pipeline as the data, so the tag always leaves together with its own word.

Top module: `line_fill_responder`

## Requirements
- R1: With `req_crit` low, the eight beats carry word indices 0,1,2,...,7 in that order, and `req_word` has no effect on the order.
- R2: With `req_crit` high, the first beat carries index `req_word`. Each later beat carries the previous index plus one, modulo 8, until eight beats have been sent.
- R3: `bus_tag` is 4 bits wide. Bits [2:0] hold the word index and bit 3 is always 0.
- R4: A request accepted at clock edge E0 produces beat k (k = 0..7) on the bus during the cycle after edge E(2+k). The eight beats arrive back to back, and `bus_ack` rises exactly one cycle after the internal acknowledge.
- R5: Each beat's `bus_data` is the stored word at linear word address `line*8 + tag[2:0]`, so the tag and the data always agree.
- R6: The word store holds, at linear word address A, the value {b,b,b,b} XOR 32'hC0DE0000, where b is the low byte of A.
- R7: Whenever `bus_ack` is low, `bus_data` and `bus_tag` are zero.
- R8: `burst_done` is high for exactly one cycle, the cycle of the eighth `bus_ack` of a burst, and never at any other time.
- R9: A request is accepted only when `busy` is low. `busy` is high from edge E0 to edge E8. A request raised while `busy` is high produces no beats and does not change the running burst.
- R10: A synchronous reset clears the beat counter, the busy flag and all pipeline registers. After a reset edge, `busy`, `bus_ack` and `burst_done` are low and no beats of the aborted burst appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Refill request strobe |
| req_line | input | 4 | Line number to return |
| req_word | input | 3 | Target word index (used only in critical-first mode) |
| req_crit | input | 1 | 1: target word first with wrap; 0: ascending from word 0 |
| busy | output | 1 | A burst is being issued |
| bus_ack | output | 1 | Bus read acknowledge, one per beat |
| bus_data | output | 32 | Beat data, zero when no acknowledge |
| bus_tag | output | 4 | Word-position tag, zero when no acknowledge |
| burst_done | output | 1 | Marks the last beat of a burst |

## Verification
Every request produces eight expected beats, and each one is due in a known cycle. If the request is driven in cycle c0 (accepted at the next edge), beat k is due in cycle c0+3+k, which follows from one sequencer cycle, one store register and one bus register. The driver stamps each expected beat with that due cycle. The monitor samples on the falling edge and compares the cycle counter, tag, data and burst-complete flag of every acknowledged beat. A beat that arrives early, arrives late, or arrives when nothing is expected is counted as a failure. On every idle cycle the monitor also checks that data and tag are zero and that no completion pulse is present. The `busy` flag is checked one cycle after acceptance.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

  typedef enum logic {
    ORDER_BASE = 1'b0,
    ORDER_CRIT = 1'b1
  } order_e;

  // Contents of the word store at a linear word address.
  function automatic logic [31:0] fill_word(input int unsigned addr);
    logic [31:0] a32;
    logic [7:0]  lo;
    a32 = addr;
    lo  = a32[7:0];
    return {lo, lo, lo, lo} ^ 32'hC0DE_0000;
  endfunction

  // Index of the first beat of a burst.
  function automatic int unsigned first_index(input order_e mode,
                                              input int unsigned target);
    return (mode == ORDER_CRIT) ? target : 0;
  endfunction

  // Index of the beat that follows idx, wrapping within the line.
  function automatic int unsigned wrap_next(input int unsigned idx,
                                            input int unsigned words);
    return (idx + 1) % words;
  endfunction

endpackage

// File: rtl/lfr_sequencer.sv
module lfr_sequencer
  import lfr_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int LINE_W = 4,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int ADDR_W = LINE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  input  logic [IDX_W-1:0]  req_word,
  input  order_e            req_mode,
  output logic              busy,
  output logic              accept,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              rd_first,
  output logic              rd_last
);

  logic [IDX_W-1:0]  beat_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LINE_W-1:0] line_q;
  logic              busy_q;

  assign accept   = req_valid && !busy_q;
  assign busy     = busy_q;
  assign rd_en    = busy_q;
  assign rd_idx   = idx_q;
  assign rd_addr  = {line_q, idx_q};
  assign rd_first = busy_q && (beat_q == '0);
  assign rd_last  = busy_q && (beat_q == IDX_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      idx_q  <= '0;
      line_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      beat_q <= '0;
      idx_q  <= IDX_W'(first_index(req_mode, int'(req_word)));
      line_q <= req_line;
    end else if (busy_q) begin
      beat_q <= beat_q + 1'b1;
      idx_q  <= IDX_W'(wrap_next(int'(idx_q), WORDS));
      if (rd_last) begin
        busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lfr_word_store.sv
module lfr_word_store
  import lfr_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int LINE_W = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int ADDR_W = LINE_W + IDX_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_first,
  input  logic              rd_last,
  output logic              int_ack,
  output logic [IDX_W-1:0]  int_idx,
  output logic              int_first,
  output logic              int_last,
  output logic [DATA_W-1:0] int_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    if (DATA_W <= 32) begin : g_narrow
      assign mem[g] = DATA_W'(fill_word(g));
    end else begin : g_wide
      assign mem[g] = {{(DATA_W-32){1'b0}}, fill_word(g)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_ack   <= 1'b0;
      int_idx   <= '0;
      int_first <= 1'b0;
      int_last  <= 1'b0;
      int_data  <= '0;
    end else begin
      int_ack   <= rd_en;
      int_idx   <= rd_idx;
      int_first <= rd_first;
      int_last  <= rd_last;
      int_data  <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/lfr_bus_stage.sv
module lfr_bus_stage #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_ack,
  input  logic [IDX_W-1:0]  int_idx,
  input  logic              int_last,
  input  logic [DATA_W-1:0] int_data,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_data,
  output logic [TAG_W-1:0]  bus_tag,
  output logic              burst_done
);

  logic [TAG_W-1:0] tag_next;

  always_comb begin
    tag_next = '0;
    tag_next[IDX_W-1:0] = int_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack    <= 1'b0;
      bus_data   <= '0;
      bus_tag    <= '0;
      burst_done <= 1'b0;
    end else begin
      bus_ack    <= int_ack;
      bus_data   <= int_ack ? int_data : '0;
      bus_tag    <= int_ack ? tag_next : '0;
      burst_done <= int_ack && int_last;
    end
  end

endmodule

// File: rtl/line_fill_responder.sv
module line_fill_responder
  import lfr_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int LINE_W = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int ADDR_W = LINE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  input  logic [IDX_W-1:0]  req_word,
  input  logic              req_crit,
  output logic              busy,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_data,
  output logic [TAG_W-1:0]  bus_tag,
  output logic              burst_done
);

  // Internal events, named so that the checker can see them.
  logic              accept;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_first;
  logic              rd_last;
  logic              int_ack;
  logic [IDX_W-1:0]  int_idx;
  logic              int_first;
  logic              int_last;
  logic [DATA_W-1:0] int_data;
  order_e            req_mode;

  assign req_mode = req_crit ? ORDER_CRIT : ORDER_BASE;

  lfr_sequencer #(.WORDS(WORDS), .LINE_W(LINE_W)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_line(req_line), .req_word(req_word),
    .req_mode(req_mode),
    .busy(busy), .accept(accept),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_idx(rd_idx),
    .rd_first(rd_first), .rd_last(rd_last)
  );

  lfr_word_store #(.WORDS(WORDS), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_idx(rd_idx),
    .rd_first(rd_first), .rd_last(rd_last),
    .int_ack(int_ack), .int_idx(int_idx), .int_first(int_first),
    .int_last(int_last), .int_data(int_data)
  );

  lfr_bus_stage #(.WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_bus (
    .clk(clk), .rst(rst),
    .int_ack(int_ack), .int_idx(int_idx), .int_last(int_last),
    .int_data(int_data),
    .bus_ack(bus_ack), .bus_data(bus_data), .bus_tag(bus_tag),
    .burst_done(burst_done)
  );

endmodule

// File: rtl/lfr_checker.sv
module lfr_checker #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              accept,
  input logic              rd_last,
  input logic              int_ack,
  input logic [IDX_W-1:0]  int_idx,
  input logic              int_first,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_data,
  input logic [TAG_W-1:0]  bus_tag,
  input logic              burst_done
);

  // R3: upper tag bits stay zero
  p_tag_msb_r3: assert property (@(posedge clk) disable iff (rst)
    bus_tag[TAG_W-1:IDX_W] == '0);

  // R4: bus acknowledge follows the internal one by one cycle, with its index
  p_ack_follows_r4: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> (bus_ack && bus_tag[IDX_W-1:0] == $past(int_idx)));

  p_no_stray_ack_r4: assert property (@(posedge clk) disable iff (rst)
    !int_ack |=> !bus_ack);

  // R1 / R2: consecutive internal beats step by one, wrapping within the line
  p_index_step_r2: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !int_first) |-> int_idx == $past(int_idx) + 1'b1);

  // R7: idle bus is quiet
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !bus_ack |-> (bus_data == '0 && bus_tag == '0));

  // R8: completion only together with a beat
  p_done_with_ack_r8: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> bus_ack);

  // R9: accepted request sets busy; no acceptance while a burst runs
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_last && req_valid) |=> !accept);

  // R10: a reset edge leaves the block idle
  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (!busy && !bus_ack && !burst_done));

endmodule

bind line_fill_responder lfr_checker #(
  .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
  .accept(accept), .rd_last(rd_last), .int_ack(int_ack),
  .int_idx(int_idx), .int_first(int_first), .bus_ack(bus_ack),
  .bus_data(bus_data), .bus_tag(bus_tag), .burst_done(burst_done)
);

// File: tb/sim_line_fill_responder.sv
module sim_line_fill_responder;

  localparam int WORDS  = 8;
  localparam int LINE_W = 4;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 4;
  localparam int IDX_W  = 3;

  typedef struct {
    int          due;
    logic [31:0] data;
    logic [3:0]  tag;
    bit          last;
    string       req;
  } beat_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [LINE_W-1:0] req_line = '0;
  logic [IDX_W-1:0]  req_word = '0;
  logic              req_crit = 1'b0;
  logic              busy;
  logic              bus_ack;
  logic [DATA_W-1:0] bus_data;
  logic [TAG_W-1:0]  bus_tag;
  logic              burst_done;

  int    cyc = 0;
  int    n_checks = 0;
  int    n_fail = 0;
  bit    summary_done = 1'b0;
  beat_t expq[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  line_fill_responder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_line(req_line),
    .req_word(req_word), .req_crit(req_crit), .busy(busy),
    .bus_ack(bus_ack), .bus_data(bus_data), .bus_tag(bus_tag),
    .burst_done(burst_done)
  );

  // Stored word per R6, written from the requirement.
  function automatic logic [31:0] model_word(input int line, input int idx);
    int a;
    logic [7:0] b;
    a = line * 8 + idx;
    b = a[7:0];
    return {b ^ 8'hC0, b ^ 8'hDE, b, b};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic print_summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    end
  endtask

  // Driver: issue one request and queue its eight expected beats.
  task automatic issue(input int line, input int tgt, input bit crit, input string req);
    int c0;
    @(posedge clk); #1;
    while (busy) begin
      @(posedge clk); #1;
    end
    req_valid = 1'b1;
    req_line  = LINE_W'(line);
    req_word  = IDX_W'(tgt);
    req_crit  = crit;
    c0 = cyc;
    for (int k = 0; k < WORDS; k++) begin
      beat_t b;
      int idx;
      idx    = crit ? (tgt + k) % WORDS : k;
      b.due  = c0 + 3 + k;
      b.data = model_word(line, idx);
      b.tag  = 4'(idx);
      b.last = (k == WORDS - 1);
      b.req  = req;
      expq.push_back(b);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    check(busy === 1'b1, "R9 busy after accept", 32'(busy), 32'd1);
  endtask

  task automatic wait_drain();
    while (expq.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  // Monitor: compares every acknowledged beat with the scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_ack) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9 unexpected beat", {28'd0, bus_tag}, 32'd0);
        end else begin
          beat_t e;
          e = expq.pop_front();
          check(cyc == e.due, "R4 beat timing", 32'(cyc), 32'(e.due));
          check(bus_tag == e.tag, {e.req, " tag order, R3"}, {28'd0, bus_tag}, {28'd0, e.tag});
          check(bus_data == e.data, "R5 R6 data matches tag", bus_data, e.data);
          check(burst_done == e.last, "R8 burst_done", 32'(burst_done), 32'(e.last));
        end
      end else begin
        check(bus_data == '0 && bus_tag == '0, "R7 idle zero",
              bus_data | 32'(bus_tag), 32'd0);
        check(!burst_done, "R8 done without ack", 32'(burst_done), 32'd0);
        if (expq.size() != 0 && cyc >= expq[0].due) begin
          check(1'b0, "R4 beat missing", 32'(cyc), 32'(expq[0].due));
          void'(expq.pop_front());
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog expired", 32'(cyc), 32'd0);
    print_summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !bus_ack && !burst_done, "R10 reset state",
          {29'd0, busy, bus_ack, burst_done}, 32'd0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R1: ascending order; a nonzero target must not change it
    issue(2, 0, 1'b0, "R1");
    issue(5, 6, 1'b0, "R1");
    wait_drain();

    // R2: every target index, several lines, queued back to back
    for (int t = 0; t < WORDS; t++) issue(t + 7, t, 1'b1, "R2");
    wait_drain();

    // R9: requests raised during a burst are ignored
    issue(3, 4, 1'b1, "R9");
    req_valid = 1'b1;
    req_line  = 4'd11;
    req_word  = 3'd1;
    req_crit  = 1'b0;
    repeat (4) begin
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
    wait_drain();
    repeat (6) @(posedge clk);

    // R10: reset in the middle of a burst
    issue(9, 5, 1'b1, "R10");
    repeat (3) begin
      @(posedge clk); #1;
    end
    rst = 1'b1;
    @(posedge clk); #1;
    check(!busy && !bus_ack && !burst_done, "R10 cleared mid-burst",
          {29'd0, busy, bus_ack, burst_done}, 32'd0);
    rst = 1'b0;
    expq.delete();
    repeat (12) @(posedge clk);

    // Recovery after reset, both modes on the top line
    issue(15, 7, 1'b1, "R2");
    issue(15, 3, 1'b0, "R1");
    wait_drain();

    print_summary();
    $finish;
  end

endmodule